// File: doc/BRIEF.md
# USB Host Receive Endpoint Controller

This block runs the receive-side handshake of a single host-mode USB endpoint. A packet engine signals each received packet with a one-cycle strobe that carries the packet length and a PID-error flag. The block raises a packet-ready flag and counts the bytes that the CPU (one byte per read) or a DMA engine (a fixed chunk per read) takes out of the receive FIFO. It compares that count against a programmed maximum packet size.

Software controls the endpoint through a byte-wide register port with four addresses: status, control, and two bytes of maximum packet size. The block can drop the ready flag by itself once a full-size packet has been fully unloaded. It can chain a request for the next IN packet to every fall of the ready flag. It requests DMA service while a packet waits, and it reports PID errors only for isochronous traffic. A short packet disarms the automatic request, so software regains control at the end of a transfer.

Top module: `rxep_host_ctrl`

## Requirements
- R1: After reset, every status and control bit, the maximum packet size and all outputs read 0.
- R2: With auto-clear enabled (control bit 0), a packet whose length is at least the maximum size has its ready flag (status bit 0, output rx_ready) cleared at the clock edge of the FIFO read that brings the unload count to or past the maximum size.
- R3: A packet shorter than the maximum size keeps the ready flag set however many bytes are read. A status write with bit 0 = 0 clears the flag at the next edge. A write with bit 0 = 1 has no effect on it.
- R4: With auto-request enabled (control bit 1), every 1-to-0 change of the ready flag sets the request bit (status bit 1, output req_pkt). Software writes status bit 1 directly. Acceptance of a packet clears it.
- R5: A packet strobe whose length is below the maximum size clears the auto-request enable at the next edge, and that takes priority over a software write in the same cycle.
- R6: dma_req is 1 exactly while the DMA enable (control bit 2) and the ready flag are both 1.
- R7: A DMA read adds DMA_BYTES to the unload count and a CPU read adds 1. Reads while the ready flag is 0 do not count.
- R8: The PID-error bit (status bit 2, output pid_err) is set by a packet carrying a PID error only when isochronous mode (control bit 3) is 1. It clears on the next packet or when the ready flag clears, and software writes do not change it.
- R9: Each accepted packet sets the ready flag and restarts the unload count from 0.
- R10: A software clear and an automatic clear in the same cycle form one clear event. The ready flag goes to 0 and the request bit is set.
- R11: Address 2 holds bits 7:0 and address 3 holds the upper bits of the maximum packet size. Unimplemented bits read 0, and reads are combinational on csr_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 2 | Register address: 0 status, 1 control, 2/3 max size bytes |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data for csr_addr |
| pkt_valid | input | 1 | One-cycle strobe: a packet has been received |
| pkt_len | input | MAXP_W | Length in bytes of the received packet |
| pkt_pid_err | input | 1 | Received packet had a PID error |
| cpu_rd | input | 1 | CPU read of one byte from the receive FIFO |
| dma_rd | input | 1 | DMA read of a DMA_BYTES chunk from the receive FIFO |
| rx_ready | output | 1 | Packet-ready flag |
| req_pkt | output | 1 | Request for the next IN packet |
| dma_req | output | 1 | DMA service request |
| pid_err | output | 1 | Isochronous PID error status |

## Verification
The bench builds the block with its defaults, an 11-bit maximum packet size and 4-byte DMA chunks. With those values it programs sizes of 2, 8 and 10 bytes, so a full unload takes only a few reads. A size of 10 is not a multiple of the chunk, so the count overshoots the limit. The 11-bit width lets the bench show the masking of the upper size byte. A behavioural reference model predicts every output and the register read data on every clock. Directed sequences cover the same-cycle software and automatic clear, reads that arrive while idle, and PID errors in both transfer modes.

// File: rtl/rxep_pkg.sv
package rxep_pkg;

  typedef enum logic [1:0] {
    ADDR_STAT  = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_MAXLO = 2'd2,
    ADDR_MAXHI = 2'd3
  } csr_addr_e;

  // control register layout, MSB first: iso, dma_en, auto_req, auto_clr
  typedef struct packed {
    logic iso;
    logic dma_en;
    logic auto_req;
    logic auto_clr;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rxep_csr.sv
module rxep_csr
  import rxep_pkg::*;
#(
  parameter int MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              short_pkt,
  output ctrl_t             ctrl,
  output logic [MAXP_W-1:0] maxp
);

  localparam int NLANE = (MAXP_W + 7) / 8;

  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;
  logic  ctrl_wr;

  assign ctrl_wr = we && (addr == ADDR_CTRL);

  // next state: software write, then hardware disarm of auto-request wins
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    end
    if (short_pkt) begin
      ctrl_d.auto_req = 1'b0;
    end
  end

  assign ctrl_en = ctrl_wr || short_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  // maximum packet size, one register lane per byte address
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = ((MAXP_W - 8 * g) >= 8) ? 8 : (MAXP_W - 8 * g);
    localparam logic [1:0] LANE_ADDR = 2'(2 + g);
    logic [LW-1:0] lane_q;
    logic          lane_en;

    assign lane_en = we && (addr == LANE_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_en) begin
        lane_q <= wdata[LW-1:0];
      end
    end

    assign maxp[8*g +: LW] = lane_q;
  end

  // R5
  areq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_pkt |=> !ctrl_q.auto_req);

endmodule

// File: rtl/rxep_unload_cnt.sv
module rxep_unload_cnt #(
  parameter int MAXP_W    = 11,
  parameter int DMA_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [MAXP_W-1:0] pkt_len,
  input  logic [MAXP_W-1:0] maxp,
  input  logic              rdy,
  input  logic              cpu_rd,
  input  logic              dma_rd,
  output logic              short_pkt,
  output logic              full_pkt,
  output logic              reach_max
);

  localparam int CNT_W = MAXP_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, inc, sat;
  logic [CNT_W:0]   sum;
  logic             cnt_en;
  logic             full_q, full_d;
  logic             step;

  always_comb begin
    inc = '0;
    if (dma_rd) inc = inc + CNT_W'(DMA_BYTES);
    if (cpu_rd) inc = inc + CNT_W'(1);
  end

  assign step = rdy && (inc != '0);
  assign sum  = {1'b0, cnt_q} + {1'b0, inc};
  assign sat  = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  assign short_pkt = pkt_valid && (pkt_len < maxp);
  assign full_d    = (pkt_len >= maxp);

  assign cnt_en = pkt_valid || step;
  assign cnt_d  = pkt_valid ? '0 : sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (pkt_valid) begin
      full_q <= full_d;
    end
  end

  assign full_pkt  = full_q;
  assign reach_max = step && full_q && (sum >= {2'b00, maxp});

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> (cnt_q == '0));

endmodule

// File: rtl/rxep_handshake.sv
module rxep_handshake
  import rxep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_valid,
  input  logic       pkt_pid_err,
  input  ctrl_t      ctrl,
  input  logic       stat_we,
  input  logic [1:0] stat_wbits,
  input  logic       reach_max,
  input  logic       full_pkt,
  output logic       rdy,
  output logic       req,
  output logic       pid
);

  logic rdy_q, rdy_d, rdy_en;
  logic req_q, req_d, req_en;
  logic pid_q, pid_d, pid_en;
  logic sw_clr, auto_clr, clr_evt;

  // software and automatic clears merge into one event
  assign sw_clr   = stat_we && !stat_wbits[0];
  assign auto_clr = ctrl.auto_clr && reach_max;
  assign clr_evt  = rdy_q && !pkt_valid && (sw_clr || auto_clr);

  always_comb begin
    rdy_d = rdy_q;
    if (pkt_valid)    rdy_d = 1'b1;
    else if (clr_evt) rdy_d = 1'b0;
  end
  assign rdy_en = pkt_valid || clr_evt;

  always_comb begin
    req_d = req_q;
    if (pkt_valid)                      req_d = 1'b0;
    else if (clr_evt && ctrl.auto_req)  req_d = 1'b1;
    else if (stat_we)                   req_d = stat_wbits[1];
  end
  assign req_en = pkt_valid || (clr_evt && ctrl.auto_req) || stat_we;

  always_comb begin
    pid_d = pid_q;
    if (pkt_valid)    pid_d = ctrl.iso && pkt_pid_err;
    else if (clr_evt) pid_d = 1'b0;
  end
  assign pid_en = pkt_valid || clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
    end else if (rdy_en) begin
      rdy_q <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q <= 1'b0;
    end else if (pid_en) begin
      pid_q <= pid_d;
    end
  end

  assign rdy = rdy_q;
  assign req = req_q;
  assign pid = pid_q;

  // R4
  areq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy_q) && $past(ctrl.auto_req)) |-> req_q);

  // R3
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !full_pkt && !pkt_valid && !sw_clr) |=> rdy_q);

  // R8
  pid_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !ctrl.iso) |=> !pid_q);

endmodule

// File: rtl/rxep_host_ctrl.sv
module rxep_host_ctrl
  import rxep_pkg::*;
#(
  parameter int MAXP_W    = 11,
  parameter int DMA_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        csr_addr,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              pkt_valid,
  input  logic [MAXP_W-1:0] pkt_len,
  input  logic              pkt_pid_err,
  input  logic              cpu_rd,
  input  logic              dma_rd,
  output logic              rx_ready,
  output logic              req_pkt,
  output logic              dma_req,
  output logic              pid_err
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ctrl_t             ctrl;
  logic [MAXP_W-1:0] maxp;
  logic [15:0]       maxp_ext;
  logic              short_pkt, full_pkt, reach_max;
  logic              stat_we;
  logic              rdy, req, pid;

  assign stat_we = csr_we && (csr_addr == ADDR_STAT);

  rxep_csr #(.MAXP_W(MAXP_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (csr_we),
    .addr      (csr_addr),
    .wdata     (csr_wdata),
    .short_pkt (short_pkt),
    .ctrl      (ctrl),
    .maxp      (maxp)
  );

  rxep_unload_cnt #(.MAXP_W(MAXP_W), .DMA_BYTES(DMA_BYTES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pkt_valid (pkt_valid),
    .pkt_len   (pkt_len),
    .maxp      (maxp),
    .rdy       (rdy),
    .cpu_rd    (cpu_rd),
    .dma_rd    (dma_rd),
    .short_pkt (short_pkt),
    .full_pkt  (full_pkt),
    .reach_max (reach_max)
  );

  rxep_handshake u_hs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pkt_valid   (pkt_valid),
    .pkt_pid_err (pkt_pid_err),
    .ctrl        (ctrl),
    .stat_we     (stat_we),
    .stat_wbits  (csr_wdata[1:0]),
    .reach_max   (reach_max),
    .full_pkt    (full_pkt),
    .rdy         (rdy),
    .req         (req),
    .pid         (pid)
  );

  assign maxp_ext = 16'(maxp);

  always_comb begin
    unique case (csr_addr)
      ADDR_STAT:  csr_rdata = {5'b0, pid, req, rdy};
      ADDR_CTRL:  csr_rdata = {{(8-CTRL_W){1'b0}}, ctrl};
      ADDR_MAXLO: csr_rdata = maxp_ext[7:0];
      default:    csr_rdata = maxp_ext[15:8];
    endcase
  end

  assign rx_ready = rdy;
  assign req_pkt  = req;
  assign pid_err  = pid;
  assign dma_req  = ctrl.dma_en && rdy;

  // R6
  dma_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(rx_ready) |-> !dma_req);

endmodule

// File: tb/rxep_host_ctrl_tb.sv
module rxep_host_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP_W     = 11;
  localparam int DMA_BYTES  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        a;
  logic              we;
  logic [7:0]        wd;
  logic [7:0]        rdata;
  logic              pv;
  logic [MAXP_W-1:0] plen;
  logic              ppe, crd, drd;
  logic              rx_ready, req_pkt, dma_req, pid_err;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit m_rdy, m_req, m_pid, m_full;
  bit m_aclr, m_areq, m_dma, m_iso;
  int m_maxp, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxep_host_ctrl #(.MAXP_W(MAXP_W), .DMA_BYTES(DMA_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(a), .csr_we(we), .csr_wdata(wd),
    .csr_rdata(rdata), .pkt_valid(pv), .pkt_len(plen), .pkt_pid_err(ppe),
    .cpu_rd(crd), .dma_rd(drd), .rx_ready(rx_ready), .req_pkt(req_pkt),
    .dma_req(dma_req), .pid_err(pid_err)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int model_rdata(logic [1:0] ad);
    case (ad)
      2'd0:    return (int'(m_pid) << 2) | (int'(m_req) << 1) | int'(m_rdy);
      2'd1:    return (int'(m_iso) << 3) | (int'(m_dma) << 2) | (int'(m_areq) << 1) | int'(m_aclr);
      2'd2:    return m_maxp & 8'hFF;
      default: return (m_maxp >> 8) & 8'hFF;
    endcase
  endfunction

  task automatic model_step();
    int  inc;
    bit  shrt, reach, swclr, clr;
    bit  n_rdy, n_req, n_pid, n_full, n_areq;
    int  n_cnt, n_maxp;
    inc   = (drd ? DMA_BYTES : 0) + (crd ? 1 : 0);
    shrt  = pv && (int'(plen) < m_maxp);
    reach = m_rdy && m_full && (inc > 0) && (m_cnt + inc >= m_maxp);
    swclr = we && (a == 2'd0) && !wd[0];
    clr   = m_rdy && !pv && (swclr || (m_aclr && reach));
    n_rdy = pv ? 1'b1 : (clr ? 1'b0 : m_rdy);
    if (pv)                 n_req = 1'b0;
    else if (clr && m_areq) n_req = 1'b1;
    else if (we && a == 2'd0) n_req = wd[1];
    else                    n_req = m_req;
    n_pid  = pv ? (m_iso && ppe) : (clr ? 1'b0 : m_pid);
    n_full = pv ? (int'(plen) >= m_maxp) : m_full;
    if (pv) n_cnt = 0;
    else if (m_rdy && inc > 0) n_cnt = (m_cnt + inc > 4095) ? 4095 : m_cnt + inc;
    else n_cnt = m_cnt;
    n_maxp = m_maxp;
    if (we && a == 2'd2) n_maxp = (m_maxp & 16'h0700) | int'(wd);
    if (we && a == 2'd3) n_maxp = (m_maxp & 16'h00FF) | (int'(wd[2:0]) << 8);
    n_areq = m_areq;
    if (we && a == 2'd1) begin
      m_aclr = wd[0]; n_areq = wd[1]; m_dma = wd[2]; m_iso = wd[3];
    end
    if (shrt) n_areq = 1'b0;
    m_rdy = n_rdy; m_req = n_req; m_pid = n_pid; m_full = n_full;
    m_cnt = n_cnt; m_maxp = n_maxp; m_areq = n_areq;
  endtask

  task automatic compare_all();
    chk("R2", "rx_ready", 16'(rx_ready), 16'(m_rdy));
    chk("R4", "req_pkt",  16'(req_pkt),  16'(m_req));
    chk("R6", "dma_req",  16'(dma_req),  16'(m_dma && m_rdy));
    chk("R8", "pid_err",  16'(pid_err),  16'(m_pid));
    chk("R11", "csr_rdata", 16'(rdata), 16'(model_rdata(a)));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_in();
    we = 0; a = 2'd0; wd = '0; pv = 0; plen = '0; ppe = 0; crd = 0; drd = 0;
  endtask

  task automatic wr(logic [1:0] ad, logic [7:0] d);
    a = ad; we = 1; wd = d;
    tick();
    we = 0; a = 2'd0; wd = '0;
  endtask

  task automatic pkt(int len, bit pe);
    pv = 1; plen = MAXP_W'(len); ppe = pe;
    tick();
    pv = 0; plen = '0; ppe = 0;
  endtask

  task automatic rdn(bit c, bit d, int n);
    for (int i = 0; i < n; i++) begin
      crd = c; drd = d;
      tick();
    end
    crd = 0; drd = 0;
  endtask

  task automatic peek(logic [1:0] ad);
    a = ad;
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // R1: reset values through every register and output
    for (int ad = 0; ad < 4; ad++) begin
      peek(2'(ad));
      chk("R1", "reset register", 16'(rdata), 16'h0);
    end
    chk("R1", "reset outputs", 16'({rx_ready, req_pkt, dma_req, pid_err}), 16'h0);
    a = 2'd0;

    // full-size packet, CPU unload, auto-clear and auto-request
    wr(2'd2, 8'd8); wr(2'd3, 8'd0); wr(2'd1, 8'h03);
    pkt(8, 0);
    chk("R9", "ready on packet", 16'(rx_ready), 16'h1);
    rdn(1, 0, 7);
    chk("R2", "ready before last byte", 16'(rx_ready), 16'h1);
    rdn(1, 0, 1);
    chk("R2", "ready after full unload", 16'(rx_ready), 16'h0);
    chk("R4", "auto request after clear", 16'(req_pkt), 16'h1);

    // short packet: no auto-clear, auto-request disarmed
    pkt(5, 0);
    chk("R4", "request cleared by packet", 16'(req_pkt), 16'h0);
    peek(2'd1);
    chk("R5", "auto-request dropped", 16'(rdata), 16'h01);
    rdn(1, 0, 8);
    chk("R3", "short packet holds ready", 16'(rx_ready), 16'h1);
    wr(2'd0, 8'h01);
    chk("R3", "write 1 keeps ready", 16'(rx_ready), 16'h1);
    wr(2'd0, 8'h00);
    chk("R3", "software clear", 16'(rx_ready), 16'h0);
    chk("R5", "no request when disarmed", 16'(req_pkt), 16'h0);

    // DMA chunk unload with overshoot past a 10-byte size
    wr(2'd2, 8'd10); wr(2'd1, 8'h05);
    pkt(10, 0);
    chk("R6", "dma request while ready", 16'(dma_req), 16'h1);
    rdn(0, 1, 2);
    chk("R7", "8 bytes keep ready", 16'(rx_ready), 16'h1);
    rdn(0, 1, 1);
    chk("R7", "third chunk clears ready", 16'(rx_ready), 16'h0);
    chk("R6", "dma request drops", 16'(dma_req), 16'h0);

    // reads while idle are ignored; new packet restarts the count
    rdn(1, 0, 20);
    chk("R7", "idle reads ignored", 16'(rx_ready), 16'h0);
    pkt(10, 0);
    rdn(0, 1, 2);
    chk("R9", "count restarted", 16'(rx_ready), 16'h1);
    rdn(0, 1, 1);
    chk("R9", "clears after 12 bytes", 16'(rx_ready), 16'h0);

    // PID errors: bulk ignores, isochronous reports
    wr(2'd1, 8'h00);
    pkt(10, 1);
    chk("R8", "bulk pid error ignored", 16'(pid_err), 16'h0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h08);
    pkt(10, 1);
    chk("R8", "iso pid error set", 16'(pid_err), 16'h1);
    wr(2'd0, 8'h05);
    chk("R8", "pid error read-only", 16'(pid_err), 16'h1);
    wr(2'd0, 8'h00);
    chk("R8", "pid error cleared", 16'(pid_err), 16'h0);

    // same-cycle software and automatic clear
    wr(2'd2, 8'd2); wr(2'd1, 8'h03);
    pkt(2, 0);
    rdn(1, 0, 1);
    crd = 1; a = 2'd0; we = 1; wd = 8'h00;
    tick();
    idle_in();
    chk("R10", "merged clear ready", 16'(rx_ready), 16'h0);
    chk("R10", "merged clear request", 16'(req_pkt), 16'h1);
    wr(2'd0, 8'h00);
    chk("R4", "software clears request", 16'(req_pkt), 16'h0);
    wr(2'd0, 8'h02);
    chk("R4", "software sets request", 16'(req_pkt), 16'h1);

    // size register lanes and masking
    wr(2'd3, 8'hFF);
    peek(2'd3);
    chk("R11", "upper size masked", 16'(rdata), 16'h07);
    wr(2'd2, 8'hA5);
    peek(2'd2);
    chk("R11", "lower size byte", 16'(rdata), 16'hA5);
    pkt(1, 0);
    peek(2'd1);
    chk("R5", "short vs large size", 16'(rdata), 16'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule